// File: doc/BRIEF.md
# Dual-law SPI serial clock divider

This block derives the serial clock of an SPI master from a faster module clock. It also produces single-cycle strobes that tell a shift engine when the clock leaves its idle level and when it returns to it. A single control word holds two divide laws and a select bit. The linear law divides by 2·(N+1) with an 8-bit N. The power-of-two law divides by 2^N with a 4-bit N.

The transfer engine raises `run` to start clocking and lowers it to stop. While `run` is low the block is idle. During idle it holds the serial clock at the polarity level and takes in a new control word and polarity. Once running, it ignores changes to either. When `run` falls in the middle of an active half-period, the block finishes that half-period and only then stops. The serial clock therefore never shows a shortened pulse.

Top module: `spi_sclk_divider`

## Requirements
- R1: After reset `sclk`, `lead_stb` and `trail_stb` are all 0.
- R2: While idle, `sclk` follows `cpol` from one clock to the next and neither strobe is asserted.
- R3: With `clk_ctl[12]` = 1 (linear law), each half-period of `sclk` lasts `clk_ctl[7:0]` + 1 module clocks, so N = 0 gives half the module clock.
- R4: With `clk_ctl[12]` = 0 and `clk_ctl[11:8]` = N ≥ 1 (power-of-two law), each half-period lasts 2^(N-1) module clocks.
- R5: `run` is sampled high at rising edge k. The first `sclk` transition then follows rising edge k+H, where H is the half-period. This first transition is a leading edge.
- R6: Each `sclk` transition away from `cpol` comes with `lead_stb`, registered in the same cycle and lasting one cycle. Each return to `cpol` comes with `trail_stb` in the same way. The two strobes alternate.
- R7: Changes to `clk_ctl` and `cpol` while running have no effect on the current burst. They take effect at the next start.
- R8: `run` may fall while `sclk` is away from its idle level. The pending trailing edge still occurs, and the block then goes idle with no further leading edge.
- R9: With `clk_ctl[12]` = 0 and `clk_ctl[11:8]` = 0, `sclk` while running is the module clock (level `~cpol` while the module clock is high). Both strobes are high in every running cycle.
- R10: With `cpol` = 1 the idle level is 1, and the leading edge is a fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_ctl | input | 13 | Divide word: [7:0] linear N, [11:8] exponent N, [12] law select (1 = linear) |
| cpol | input | 1 | Idle level of the serial clock |
| run | input | 1 | High to generate clock edges, low to return to idle |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe marking a transition away from idle level |
| trail_stb | output | 1 | One-cycle strobe marking a transition back to idle level |

## Verification
The hardest case to reach from the ports is a stop request that lands in the middle of an active half-period. In that case the block must still finish the trailing edge before it goes idle. The driver lowers `run` in the cycle right after it sees a leading strobe, with both a one-cycle and a multi-cycle half-period. The scoreboard then expects exactly one more trailing event and no other events. A second hard case is a control word change during a burst. The driver writes a new word just after starting a burst and keeps the expected timing on the old word until the next start.

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider #(
  parameter int DIV_W = 8,
  parameter int EXP_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DIV_W+EXP_W:0]         clk_ctl,
  input  logic                         cpol,
  input  logic                         run,
  output logic                         sclk,
  output logic                         lead_stb,
  output logic                         trail_stb
);
  localparam int CTL_W   = DIV_W + EXP_W + 1;
  localparam int SEL_BIT = DIV_W + EXP_W;
  localparam int POW_W   = (1 << EXP_W) - 1;
  localparam int CNT_W   = (DIV_W + 1 > POW_W) ? DIV_W + 1 : POW_W;

  logic [CTL_W-1:0] cfg_q;
  logic [CNT_W-1:0] cnt_q, half_m1;
  logic             cpol_q, act_q, sclk_q, lead_q, trail_q;

  wire             lin     = cfg_q[SEL_BIT];
  wire [DIV_W-1:0] div_f   = cfg_q[DIV_W-1:0];
  wire [EXP_W-1:0] exp_f   = cfg_q[SEL_BIT-1:DIV_W];
  wire             bypass  = !lin && (exp_f == '0);
  wire             byp_on  = act_q && bypass;
  wire             at_idle = (sclk_q == cpol_q);
  wire             wrap    = (cnt_q == half_m1);

  assign half_m1 = lin ? CNT_W'(div_f)
                       : (CNT_W'(1) << (exp_f - 1'b1)) - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      cnt_q   <= '0;
      cpol_q  <= 1'b0;
      act_q   <= 1'b0;
      sclk_q  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!act_q) begin
      cfg_q   <= clk_ctl;
      cpol_q  <= cpol;
      sclk_q  <= cpol;
      cnt_q   <= '0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      act_q   <= run;
    end else begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      if (bypass) begin
        if (!run) act_q <= 1'b0;
      end else if (!run && at_idle) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else if (wrap) begin
        cnt_q   <= '0;
        sclk_q  <= ~sclk_q;
        lead_q  <= at_idle;
        trail_q <= !at_idle;
        if (!at_idle && !run) act_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sclk      = byp_on ? (cpol_q ^ clk) : sclk_q;
  assign lead_stb  = byp_on | lead_q;
  assign trail_stb = byp_on | trail_q;

  a_r6_lead_edge: assert property (@(posedge clk) disable iff (!rst_n)
    lead_q |-> (sclk_q != cpol_q) && (sclk_q != $past(sclk_q)));

  a_r6_trail_edge: assert property (@(posedge clk) disable iff (!rst_n)
    trail_q |-> (sclk_q == cpol_q) && (sclk_q != $past(sclk_q)));

  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    lead_q |=> !lead_q);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && !$past(act_q)) |-> !lead_q && !trail_q);

  a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(act_q) |-> $stable(cfg_q) && $stable(cpol_q));

  a_r8_no_lead_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && act_q) |=> !lead_q);
endmodule

// File: tb/spi_sclk_divider_bench.sv
module spi_sclk_divider_bench;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] clk_ctl = '0;
  logic        cpol = 1'b0;
  logic        run = 1'b0;
  logic        sclk, lead_stb, trail_stb;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit mon_en = 1'b0;

  typedef struct { int at; bit lead; bit lvl; } ev_t;
  ev_t exp_q[$];

  always #(PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_sclk_divider u_spi_sclk_divider (
    .clk(clk), .rst_n(rst_n), .clk_ctl(clk_ctl), .cpol(cpol), .run(run),
    .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int half_of(input logic [12:0] w);
    if (w[12]) return int'(w[7:0]) + 1;
    return 1 << (int'(w[11:8]) - 1);
  endfunction

  // Monitor: compare every observed strobe with the scoreboard head (R3 R4 R5 R6 R10)
  always @(negedge clk) begin
    if (mon_en && (lead_stb || trail_stb)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected strobe", cyc, -1);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        chk(cyc == e.at, "R3/R4/R5 edge time", cyc, e.at);
        chk(lead_stb == e.lead && trail_stb == !e.lead, "R6 strobe kind",
            int'({lead_stb, trail_stb}), int'({e.lead, !e.lead}));
        chk(sclk == e.lvl, "R6/R10 sclk level at strobe", int'(sclk), int'(e.lvl));
      end
    end
  end

  // Driver: run a burst of `halves` half-periods, optional word change mid-burst (R7)
  task automatic burst(input logic [12:0] w, input bit pol, input int halves,
                       input bit chg, input logic [12:0] w2);
    int h, c, total;
    @(negedge clk);
    clk_ctl = w; cpol = pol;
    @(negedge clk);
    h = half_of(w);
    c = cyc;
    total = (halves % 2 == 0) ? halves : halves + 1;
    for (int j = 1; j <= total; j++) begin
      ev_t e;
      e.at = c + 1 + j * h;
      e.lead = (j % 2 == 1);
      e.lvl = e.lead ? ~pol : pol;
      exp_q.push_back(e);
    end
    run = 1'b1;
    if (chg) begin
      @(negedge clk);
      clk_ctl = w2; cpol = ~pol;
    end
    while (cyc != c + 1 + halves * h) @(negedge clk);
    run = 1'b0;
    while (cyc < c + 1 + total * h + 3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 missing edges", exp_q.size(), 0);
    exp_q.delete();
    chk(lead_stb == 1'b0 && trail_stb == 1'b0, "R8 idle after stop",
        int'({lead_stb, trail_stb}), 0);
    if (chg) begin
      clk_ctl = w; cpol = pol;
      @(negedge clk); @(negedge clk);
    end
    chk(sclk == pol, "R2 idle level after burst", int'(sclk), int'(pol));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0 && lead_stb == 1'b0 && trail_stb == 1'b0, "R1 reset outputs",
        int'({sclk, lead_stb, trail_stb}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R10: idle follows cpol, no strobes while the word changes
    cpol = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(sclk == 1'b1, "R10 idle level high", int'(sclk), 1);
    for (int i = 0; i < 8; i++) begin
      clk_ctl = 13'(i * 37);
      cpol = i[0];
      @(negedge clk);
      chk(!lead_stb && !trail_stb, "R2 no strobe while idle", int'({lead_stb, trail_stb}), 0);
    end
    @(negedge clk);
    chk(sclk == cpol, "R2 sclk follows cpol", int'(sclk), int'(cpol));

    mon_en = 1'b1;
    burst(13'h1000, 1'b0, 6, 1'b0, '0);            // R3 linear N=0, half clock
    burst(13'h1003, 1'b0, 4, 1'b0, '0);            // R3 linear N=3
    burst(13'h10FF, 1'b1, 4, 1'b0, '0);            // R3 R10 linear N=255, cpol=1
    burst(13'h0100, 1'b0, 4, 1'b0, '0);            // R4 pow2 N=1
    burst(13'h0500, 1'b1, 4, 1'b0, '0);            // R4 R10 pow2 N=5
    burst(13'h0F00, 1'b0, 2, 1'b0, '0);            // R4 pow2 N=15
    burst(13'h1002, 1'b0, 4, 1'b1, 13'h1000);      // R7 change ignored while running
    burst(13'h1000, 1'b0, 2, 1'b0, '0);            // R7 new word after idle
    burst(13'h1000, 1'b0, 1, 1'b0, '0);            // R8 stop after lead, H=1
    burst(13'h0400, 1'b1, 3, 1'b0, '0);            // R8 stop after lead, H=8
    mon_en = 1'b0;

    // R9 bypass: undivided clock, both strobes every cycle
    @(negedge clk);
    clk_ctl = 13'h0000; cpol = 1'b0;
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      chk(lead_stb && trail_stb, "R9 strobes every cycle", int'({lead_stb, trail_stb}), 3);
      chk(sclk == 1'b0, "R9 sclk low with clk low", int'(sclk), 0);
      @(posedge clk); #(PER/4);
      chk(sclk == 1'b1, "R9 sclk high with clk high", int'(sclk), 1);
      @(negedge clk);
    end
    run = 1'b0;
    @(negedge clk);
    chk(!lead_stb && !trail_stb && sclk == 1'b0, "R9 bypass stops",
        int'({sclk, lead_stb, trail_stb}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule